// File: doc/BRIEF.md
# Floating-Point Condition-Code Store and Predicate Evaluator

This block keeps four 2-bit floating-point condition codes inside a 64-bit status word. A compare unit elsewhere reports its outcome as four flags (less, equal, greater, unordered), together with whether the compare was the signalling variant and whether either operand was a signalling NaN. On a strobe the block encodes that outcome and writes it into the selected code's field. It raises an invalid-operation flag for unordered outcomes that call for it. If that exception is trap-enabled, the stored code is left as it was.

The same selector picks the code that a conditional-move predicate is tested against. A 4-bit condition field chooses one of eight tests over the four-state code, and its top bit inverts the result. The predicate is purely combinational from the stored codes, so a compare written in one cycle changes the predicate from the next cycle on.

Top module: `fcc_unit`

## Requirements
- R1: While reset is held, and after it is released, the status word is all zeros; with every code at 0 the predicate is 0 for condition 4'd0 and 1 for condition 4'd8.
- R2: On a strobe the selected code is written as 0 for equal, 1 for less, 2 for greater and 3 for unordered; if several flags are set, unordered wins, then less, then greater.
- R3: Code 0 is held in status bits 11:10, and codes 1, 2 and 3 are held in bits 33:32, 35:34 and 37:36.
- R4: A compare changes only the selected code's two bits; all other status bits keep their value, bits outside the four fields stay 0, and nothing changes without a strobe.
- R5: `inv_flag` is 1 in the strobe cycle exactly when the outcome is unordered and either the compare is signalling or at least one operand is a signalling NaN.
- R6: When `inv_flag` is 1 and `inv_trap_en` is 1, the selected code is not written.
- R7: The low three condition bits select the test on the selected code c: 0 never, 1 c!=0, 2 c==1 or c==2, 3 c bit 0 set, 4 c==1, 5 c bit 1 set, 6 c==2, 7 c==3.
- R8: Condition bit 3 inverts the result of the selected test.
- R9: The predicate follows the stored codes combinationally; a compare written at a clock edge is first seen by the predicate after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_vld | input | 1 | Compare result strobe |
| cmp_lt | input | 1 | Compare outcome: less |
| cmp_eq | input | 1 | Compare outcome: equal |
| cmp_gt | input | 1 | Compare outcome: greater |
| cmp_uo | input | 1 | Compare outcome: unordered |
| cmp_sig | input | 1 | Compare is the signalling variant |
| snan_a | input | 1 | First operand is a signalling NaN |
| snan_b | input | 1 | Second operand is a signalling NaN |
| inv_trap_en | input | 1 | Invalid-operation exception is trap-enabled |
| cc_sel | input | 2 | Selects the code to write and to test |
| cond | input | 4 | Predicate condition: bit 3 inverts, bits 2:0 pick the test |
| pred | output | 1 | Predicate result |
| inv_flag | output | 1 | Invalid-operation exception for the current compare |
| status | output | 64 | Status word holding the four codes |

## Verification
The bench goes after the split field layout by keeping its own copy of all four codes and comparing the whole status word after every compare. A design that packed the codes contiguously, or wrote the wrong field, would show a status mismatch. It drives unordered outcomes with each exception cause alone, and ordered outcomes with the same causes. A design that flagged invalid on any signalling compare, or missed a NaN operand, would fail there; one that ignored the trap enable would write a blocked code. Every code is checked against all sixteen conditions, and the predicate is sampled in the strobe cycle, so a design that bypassed the new code into the predicate early, or that mis-decoded a test or its inversion, would report a wrong predicate.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UO = 2'd3
  } cc_e;

  // Lowest bit of condition code idx: code 0 sits alone at lo_base,
  // the remaining codes are packed upward from hi_base.
  function automatic int unsigned cc_lsb(input int unsigned idx,
                                         input int unsigned lo_base,
                                         input int unsigned hi_base);
    cc_lsb = (idx == 0) ? lo_base : hi_base + 2 * (idx - 1);
  endfunction

endpackage

// File: rtl/fcc_rst_sync.sv
module fcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fcc_encode.sv
module fcc_encode
  import fcc_pkg::*;
(
  input  logic cmp_lt,
  input  logic cmp_eq,
  input  logic cmp_gt,
  input  logic cmp_uo,
  input  logic cmp_sig,
  input  logic snan_a,
  input  logic snan_b,
  output cc_e  code,
  output logic invalid
);
  logic unused_eq;
  assign unused_eq = cmp_eq;

  always_comb begin
    if (cmp_uo)      code = CC_UO;
    else if (cmp_lt) code = CC_LT;
    else if (cmp_gt) code = CC_GT;
    else             code = CC_EQ;
  end

  assign invalid = cmp_uo & (cmp_sig | snan_a | snan_b);
endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import fcc_pkg::*;
#(
  parameter int unsigned STAT_W  = 64,
  parameter int unsigned NUM_CC  = 4,
  parameter int unsigned LO_BASE = 10,
  parameter int unsigned HI_BASE = 32,
  parameter int unsigned SEL_W   = $clog2(NUM_CC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_code,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [1:0]        rd_code,
  output logic [STAT_W-1:0] status_o
);
  function automatic logic [STAT_W-1:0] field_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CC; k++) begin
      m[cc_lsb(k, LO_BASE, HI_BASE) +: 2] = 2'b11;
    end
    return m;
  endfunction

  localparam logic [STAT_W-1:0] FIELD_MASK = field_mask();

  logic [STAT_W-1:0] status_q, status_d;

  // next state
  always_comb begin
    status_d = status_q;
    for (int i = 0; i < NUM_CC; i++) begin
      if (wr_en && (wr_sel == SEL_W'(i)))
        status_d[cc_lsb(i, LO_BASE, HI_BASE) +: 2] = wr_code;
    end
  end

  // register, clock enable written out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (wr_en) status_q <= status_d;
  end

  // read port for the predicate
  always_comb begin
    rd_code = 2'b00;
    for (int i = 0; i < NUM_CC; i++) begin
      if (rd_sel == SEL_W'(i))
        rd_code = status_q[cc_lsb(i, LO_BASE, HI_BASE) +: 2];
    end
  end

  assign status_o = status_q;

  // R4
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~FIELD_MASK) == '0);

  for (genvar g = 0; g < NUM_CC; g++) begin : g_fld
    localparam int unsigned LSB = cc_lsb(g, LO_BASE, HI_BASE);
    // R2
    field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(g)) |=> status_q[LSB +: 2] == $past(wr_code));
    // R4
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(status_q[LSB +: 2]));
  end
endmodule

// File: rtl/fcc_eval.sv
module fcc_eval
  import fcc_pkg::*;
(
  input  logic [1:0] code,
  input  logic [3:0] cond,
  output logic       pred
);
  logic hit;

  always_comb begin
    unique case (cond[2:0])
      3'd0: hit = 1'b0;
      3'd1: hit = (code != CC_EQ);
      3'd2: hit = (code == CC_LT) || (code == CC_GT);
      3'd3: hit = code[0];
      3'd4: hit = (code == CC_LT);
      3'd5: hit = code[1];
      3'd6: hit = (code == CC_GT);
      default: hit = (code == CC_UO);
    endcase
  end

  assign pred = hit ^ cond[3];
endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
  import fcc_pkg::*;
#(
  parameter int unsigned STAT_W  = 64,
  parameter int unsigned NUM_CC  = 4,
  parameter int unsigned LO_BASE = 10,
  parameter int unsigned HI_BASE = 32,
  parameter int unsigned SEL_W   = $clog2(NUM_CC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_vld,
  input  logic              cmp_lt,
  input  logic              cmp_eq,
  input  logic              cmp_gt,
  input  logic              cmp_uo,
  input  logic              cmp_sig,
  input  logic              snan_a,
  input  logic              snan_b,
  input  logic              inv_trap_en,
  input  logic [SEL_W-1:0]  cc_sel,
  input  logic [3:0]        cond,
  output logic              pred,
  output logic              inv_flag,
  output logic [STAT_W-1:0] status
);
  logic       rst_n_s;
  cc_e        enc_code;
  logic       enc_inv;
  logic       wr_en;
  logic [1:0] sel_code;

  fcc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fcc_encode u_enc (
    .cmp_lt  (cmp_lt),
    .cmp_eq  (cmp_eq),
    .cmp_gt  (cmp_gt),
    .cmp_uo  (cmp_uo),
    .cmp_sig (cmp_sig),
    .snan_a  (snan_a),
    .snan_b  (snan_b),
    .code    (enc_code),
    .invalid (enc_inv)
  );

  assign inv_flag = cmp_vld & enc_inv;
  assign wr_en    = cmp_vld & ~(enc_inv & inv_trap_en);

  fcc_store #(
    .STAT_W  (STAT_W),
    .NUM_CC  (NUM_CC),
    .LO_BASE (LO_BASE),
    .HI_BASE (HI_BASE),
    .SEL_W   (SEL_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_sel   (cc_sel),
    .wr_code  (enc_code),
    .rd_sel   (cc_sel),
    .rd_code  (sel_code),
    .status_o (status)
  );

  fcc_eval u_eval (
    .code (sel_code),
    .cond (cond),
    .pred (pred)
  );

  // R6
  trap_block_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (inv_flag && inv_trap_en) |=> $stable(status));
  // R5
  invalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    inv_flag |-> (cmp_uo && (cmp_sig || snan_a || snan_b)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmp_vld |=> $stable(status));
  // R7
  never_test_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cond[2:0] == 3'd0) |-> (pred == cond[3]));
  // R9
  pred_steady_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($stable(cond) && $stable(cc_sel) && $stable(status)) |-> $stable(pred));
endmodule

// File: tb/fcc_unit_tb.sv
`timescale 1ns/1ps
module fcc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_vld, cmp_lt, cmp_eq, cmp_gt, cmp_uo, cmp_sig;
  logic        snan_a, snan_b, inv_trap_en;
  logic [1:0]  cc_sel;
  logic [3:0]  cond;
  logic        pred, inv_flag;
  logic [63:0] status;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [1:0] model [4];

  always #2 clk = ~clk;

  fcc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_lt(cmp_lt),
    .cmp_eq(cmp_eq), .cmp_gt(cmp_gt), .cmp_uo(cmp_uo), .cmp_sig(cmp_sig),
    .snan_a(snan_a), .snan_b(snan_b), .inv_trap_en(inv_trap_en),
    .cc_sel(cc_sel), .cond(cond), .pred(pred), .inv_flag(inv_flag),
    .status(status)
  );

  // {sel[16:15], flags uo,gt,eq,lt [14:11], sig[10], snan_a[9], snan_b[8],
  //  trap[7], cond[6:3], expected code[2:1], expected invalid[0]}
  localparam logic [16:0] VEC [12] = '{
    {2'd0, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1,  2'd0, 1'b0},
    {2'd1, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4,  2'd1, 1'b0},
    {2'd2, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6,  2'd2, 1'b0},
    {2'd3, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7,  2'd3, 1'b0},
    {2'd0, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  2'd3, 1'b1},
    {2'd1, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5,  2'd3, 1'b1},
    {2'd2, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd13, 2'd3, 1'b1},
    {2'd3, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10, 2'd1, 1'b0},
    {2'd0, 4'b0100, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2,  2'd2, 1'b0},
    {2'd1, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1, 4'd15, 2'd3, 1'b1},
    {2'd2, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9,  2'd0, 1'b0},
    {2'd3, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8,  2'd3, 1'b1}
  };

  function automatic logic pred_ref(input logic [1:0] c, input logic [3:0] k);
    logic r;
    case (k[2:0])
      3'd0: r = 1'b0;
      3'd1: r = (c != 2'd0);
      3'd2: r = (c == 2'd1) || (c == 2'd2);
      3'd3: r = c[0];
      3'd4: r = (c == 2'd1);
      3'd5: r = c[1];
      3'd6: r = (c == 2'd2);
      default: r = (c == 2'd3);
    endcase
    return r ^ k[3];
  endfunction

  function automatic logic [63:0] status_ref();
    logic [63:0] s;
    s = '0;
    s[11:10] = model[0];
    s[33:32] = model[1];
    s[35:34] = model[2];
    s[37:36] = model[3];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [3:0] f);
    {cmp_uo, cmp_gt, cmp_eq, cmp_lt} = f;
  endtask

  // One compare: drive at negedge, check the strobe cycle, then the result.
  task automatic do_cmp(input logic [16:0] v);
    logic [1:0] sel;
    sel = v[16:15];
    @(negedge clk);
    cc_sel = sel;
    set_flags(v[14:11]);
    cmp_sig = v[10]; snan_a = v[9]; snan_b = v[8]; inv_trap_en = v[7];
    cond = v[6:3];
    cmp_vld = 1'b1;
    #1;
    chk(inv_flag == v[0], "R5 invalid flag", 64'(inv_flag), 64'(v[0]));
    chk(pred == pred_ref(model[sel], cond), "R9 predicate still on old code",
        64'(pred), 64'(pred_ref(model[sel], cond)));
    @(negedge clk);
    cmp_vld = 1'b0;
    if (!(v[0] && v[7])) model[sel] = v[2:1];
    #1;
    chk(status == status_ref(), "R2/R3/R4/R6 status word", status, status_ref());
    chk(pred == pred_ref(model[sel], cond), "R7/R8 predicate on new code",
        64'(pred), 64'(pred_ref(model[sel], cond)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_vld = 1'b0; set_flags(4'b0000);
    cmp_sig = 1'b0; snan_a = 1'b0; snan_b = 1'b0; inv_trap_en = 1'b0;
    cc_sel = 2'd0; cond = 4'd0;
    for (int i = 0; i < 4; i++) model[i] = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(status == 64'd0, "R1 status in reset", status, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(status == 64'd0, "R1 status after reset", status, 64'd0);
    cond = 4'd0; #1;
    chk(pred == 1'b0, "R1 never test", 64'(pred), 64'd0);
    cond = 4'd8; #1;
    chk(pred == 1'b1, "R1 inverted never test", 64'(pred), 64'd1);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 12; i++) do_cmp(VEC[i]);

    // R2 priority: unordered over less, less over greater
    do_cmp({2'd2, 4'b1001, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 2'd3, 1'b0});
    do_cmp({2'd2, 4'b0101, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 2'd1, 1'b0});

    // R4: flags without strobe change nothing
    @(negedge clk);
    cc_sel = 2'd1; set_flags(4'b0100); cmp_vld = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(status == status_ref(), "R4 no strobe no write", status, status_ref());

    // R7 R8: every test against every code on field 0
    for (int c = 0; c < 4; c++) begin
      logic [3:0] fl;
      fl = (c == 0) ? 4'b0010 : (c == 1) ? 4'b0001 : (c == 2) ? 4'b0100 : 4'b1000;
      do_cmp({2'd0, fl, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'(c), 1'b0});
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        cond = 4'(k);
        #1;
        chk(pred == pred_ref(2'(c), 4'(k)), "R7/R8 test decode",
            64'(pred), 64'(pred_ref(2'(c), 4'(k))));
      end
    end

    // R1: reset in mid-run clears the word at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(status == 64'd0, "R1 asynchronous clear", status, 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule